// File: doc/BRIEF.md
# Raster Line and Dot Timer with Blanking Status

This block produces the raster timing of a video frame made of 262 lines of 256 dots each, advancing by one dot on every clock. It keeps a dot counter and a line counter, presents them as raster coordinates to the rendering logic, and lets a processor read both positions, poll a sticky vertical-blanking flag and program a line on which an interrupt request is raised.

The processor side is a small register window: a 3-bit address, a read strobe, a write strobe, an 8-bit write bus and an 8-bit read bus. The read bus always shows the selected register. The strobe only matters for the status register, where a read clears the flag. The line position reads as the true line number during the top blanking and active lines. From the first blanking line at the bottom to the end of the frame it reads as the fixed code 0xFF. The only writable register holds the interrupt line. A value of zero in it turns the interrupt off.

Top module: `raster_timer`

## Requirements
- R1: After reset the dot position is 0. It rises by one per clock up to 255, then returns to 0 and moves the line position on by one.
- R2: The line position runs from 0 to 261, then returns to 0. After reset it is 0.
- R3: Reading address 0 returns the line number while the line position is 0 to 199.
- R4: Reading address 0 returns 0xFF while the line position is 200 to 261.
- R5: Reading address 1 returns the current dot position.
- R6: Reading address 3 returns the blanking flag in bit 7, with bits 6:0 always 0. The flag becomes 1 on the first dot of line 200 and stays 1 until it is read.
- R7: A cycle with the read strobe high on address 3 clears the flag from the next cycle on. If that cycle is also the last dot of line 199, the flag becomes 1 instead.
- R8: Address 2 holds the interrupt line. It reads back the last value written to it and is 0 after reset.
- R9: The irq output is high for exactly one clock, on dot 0 of the line whose number equals the interrupt line. While the interrupt line is 0, irq stays low.
- R10: Writes to addresses 0, 1 and 3 change nothing. Addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register select |
| rd_stb | input | 1 | Read strobe (clears status on address 3) |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents |
| line_out | output | 9 | Current line position |
| dot_out | output | 9 | Current dot position |
| irq | output | 1 | One-clock interrupt request |

## Verification
The address select rotates on every idle cycle over a run of more than two frames. This checks the read bus for all eight codes and separates true line numbers from the 0xFF code on both sides of line 200 and across the frame wrap. Writes with distinctive values go to every read-only address, which shows whether a write reaches any counter or the flag. A status read is placed exactly on the last dot of line 199, and further reads and non-reads follow later in the blanking period. Together they show whether set wins over clear, whether the flag holds without a read and whether it clears after one. One frame runs with a nonzero interrupt line and another with zero. Counting the pulses separates a working compare from a disabled one, and the cycle-by-cycle comparison shows where each pulse falls.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int DOT_W  = 8;
    localparam int LINE_W = 9;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam int DEF_DOTS   = 256;
    localparam int DEF_LINES  = 262;
    localparam int DEF_VBLANK = 200;

    typedef logic [DOT_W-1:0]  dot_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        line_t line;
        dot_t  dot;
    } pos_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LINE = 3'd0,
        SEL_DOT  = 3'd1,
        SEL_CMP  = 3'd2,
        SEL_STAT = 3'd3
    } sel_e;

    localparam data_t BLANK_CODE = 8'hFF;
    localparam int    STAT_BIT   = 7;

    function automatic data_t line_code(line_t l, line_t vb_line);
        return (l < vb_line) ? l[DATA_W-1:0] : BLANK_CODE;
    endfunction

    function automatic data_t stat_code(logic flag);
        data_t d;
        d = '0;
        d[STAT_BIT] = flag;
        return d;
    endfunction
endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int DOTS  = DEF_DOTS,
    parameter int LINES = DEF_LINES
) (
    input  logic  clk,
    input  logic  rst,
    output pos_t  pos,
    output logic  line_end,
    output line_t next_line
);
    localparam dot_t  LAST_DOT  = dot_t'(DOTS - 1);
    localparam line_t LAST_LINE = line_t'(LINES - 1);

    assign line_end  = (pos.dot == LAST_DOT);
    assign next_line = (pos.line == LAST_LINE) ? '0 : pos.line + line_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (line_end) begin
            pos.dot  <= '0;
            pos.line <= next_line;
        end else begin
            pos.dot <= pos.dot + dot_t'(1);
        end
    end
endmodule

// File: rtl/raster_status.sv
module raster_status (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clear_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (set_pulse) flag <= 1'b1;
        else if (clear_req) flag <= 1'b0;
    end
endmodule

// File: rtl/raster_irq.sv
module raster_irq
    import raster_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  data_t wr_data,
    input  logic  line_end,
    input  line_t next_line,
    output data_t cmp,
    output logic  irq
);
    logic hit;

    assign hit = line_end && (cmp != '0) && (next_line == line_t'(cmp));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '0;
            irq <= 1'b0;
        end else begin
            irq <= hit;
            if (wr_en) cmp <= wr_data;
        end
    end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int DOTS   = DEF_DOTS,
    parameter int LINES  = DEF_LINES,
    parameter int VBLANK = DEF_VBLANK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LINE_W-1:0] line_out,
    output logic [LINE_W-1:0] dot_out,
    output logic             irq
);
    localparam line_t VB_LINE = line_t'(VBLANK);

    pos_t  pos;
    logic  line_end;
    line_t next_line;
    logic  vb_flag;
    data_t cmp;
    logic  vb_set;
    logic  stat_rd;
    logic  cmp_wr;

    raster_counter #(.DOTS(DOTS), .LINES(LINES)) u_cnt (
        .clk(clk), .rst(rst), .pos(pos),
        .line_end(line_end), .next_line(next_line)
    );

    assign vb_set  = line_end && (next_line == VB_LINE);
    assign stat_rd = rd_stb && (reg_addr == SEL_STAT);
    assign cmp_wr  = wr_stb && (reg_addr == SEL_CMP);

    raster_status u_stat (
        .clk(clk), .rst(rst), .set_pulse(vb_set),
        .clear_req(stat_rd), .flag(vb_flag)
    );

    raster_irq u_irq (
        .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_data(wr_data),
        .line_end(line_end), .next_line(next_line),
        .cmp(cmp), .irq(irq)
    );

    always_comb begin
        case (sel_e'(reg_addr))
            SEL_LINE: rd_data = line_code(pos.line, VB_LINE);
            SEL_DOT:  rd_data = pos.dot;
            SEL_CMP:  rd_data = cmp;
            SEL_STAT: rd_data = stat_code(vb_flag);
            default:  rd_data = '0;
        endcase
    end

    assign line_out = pos.line;
    assign dot_out  = {1'b0, pos.dot};
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk
    import raster_pkg::*;
#(
    parameter int DOTS   = DEF_DOTS,
    parameter int LINES  = DEF_LINES,
    parameter int VBLANK = DEF_VBLANK
) (
    input logic  clk,
    input logic  rst,
    input dot_t  dot,
    input line_t line,
    input logic  flag,
    input logic  stat_rd,
    input data_t cmp,
    input logic  irq
);
    localparam dot_t  LAST_DOT  = dot_t'(DOTS - 1);
    localparam line_t LAST_LINE = line_t'(LINES - 1);
    localparam line_t PRE_VB    = line_t'(VBLANK - 1);

    a_r1_dot_step: assert property (@(posedge clk) disable iff (rst)
        (dot != LAST_DOT) |=> (dot == $past(dot) + dot_t'(1)));
    a_r1_dot_wrap: assert property (@(posedge clk) disable iff (rst)
        (dot == LAST_DOT) |=> (dot == '0));
    a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
        (dot != LAST_DOT) |=> $stable(line));
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (dot == LAST_DOT && line == LAST_LINE) |=> (line == '0));
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        (dot == LAST_DOT && line == PRE_VB) |=> flag);
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !(dot == LAST_DOT && line == PRE_VB)) |=> !flag);
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (flag && !stat_rd) |=> flag);
    a_r9_irq_dot0: assert property (@(posedge clk) disable iff (rst)
        irq |-> (dot == '0));
    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |=> !irq);
endmodule

bind raster_timer raster_timer_chk #(.DOTS(DOTS), .LINES(LINES), .VBLANK(VBLANK)) i_chk (
    .clk(clk), .rst(rst), .dot(pos.dot), .line(pos.line), .flag(vb_flag),
    .stat_rd(stat_rd), .cmp(cmp), .irq(irq)
);

// File: tb/test_raster_timer.sv
module test_raster_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [8:0] line_out;
    logic [8:0] dot_out;
    logic       irq;

    int total = 0;
    int bad = 0;
    int mh = 0, mv = 0, mcmp = 0, mirq = 0, mflag = 0;
    int irq_cnt = 0;
    int rot = 0;

    raster_timer i_raster_timer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
        .line_out(line_out), .dot_out(dot_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return (mv < 200) ? mv : 255;
            1: return mh;
            2: return mcmp;
            3: return mflag ? 128 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        case (a)
            0: return (mv < 200) ? "R3" : "R4";
            1: return "R5";
            2: return "R8";
            3: return "R6";
            default: return "R10";
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mv = 0; mflag = 0; mcmp = 0; mirq = 0;
        end else begin
            int nv;
            nv = (mh == 255) ? ((mv == 261) ? 0 : mv + 1) : mv;
            mirq = (mh == 255 && mcmp != 0 && nv == mcmp) ? 1 : 0;
            if (mh == 255 && mv == 199) mflag = 1;
            else if (rd_stb && reg_addr == 3) mflag = 0;
            if (wr_stb && reg_addr == 2) mcmp = wr_data;
            mh = (mh == 255) ? 0 : mh + 1;
            mv = nv;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R1 dot", int'(dot_out), mh);
            check("R2 line", int'(line_out), mv);
            check("R9 irq", int'(irq), mirq);
            check(rd_tag(int'(reg_addr)), int'(rd_data), exp_rd(int'(reg_addr)));
            if (irq) irq_cnt++;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            step();
            rd_stb = 0; wr_stb = 0;
            reg_addr = 3'(rot);
            rot++;
        end
    endtask

    task automatic wait_pos(int line, int dot);
        rd_stb = 0; wr_stb = 0;
        while (!(mv == line && mh == dot)) begin
            step();
            reg_addr = 3'(rot);
            rot++;
        end
    endtask

    task automatic write_reg(int a, int d);
        step();
        reg_addr = 3'(a); wr_data = 8'(d); wr_stb = 1; rd_stb = 0;
        step();
        wr_stb = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        reg_addr = 2;
        #1;
        check("R1 reset dot", int'(dot_out), 0);
        check("R2 reset line", int'(line_out), 0);
        check("R8 reset cmp", int'(rd_data), 0);
        reg_addr = 3;
        #1;
        check("R6 reset status", int'(rd_data), 0);

        // writes to read-only addresses
        write_reg(0, 8'h55);
        write_reg(1, 8'hAA);
        write_reg(3, 8'hFF);
        @(negedge clk);
        check("R10 status unchanged", int'(rd_data), 0);
        reg_addr = 0;
        #1;
        check("R10 line unchanged", int'(rd_data), mv);
        reg_addr = 1;
        #1;
        check("R10 dot unchanged", int'(rd_data), mh);
        reg_addr = 5;
        #1;
        check("R10 unused address", int'(rd_data), 0);

        write_reg(2, 5);
        reg_addr = 2;
        @(negedge clk);
        check("R8 cmp readback", int'(rd_data), 5);

        idle(300);

        // status read on the very cycle the flag gets set
        wait_pos(199, 255);
        reg_addr = 3; rd_stb = 1;
        step();
        rd_stb = 0;
        @(negedge clk);
        check("R7 set wins over read", int'(rd_data), 128);

        // flag holds without a read
        wait_pos(230, 17);
        reg_addr = 3;
        @(negedge clk);
        check("R6 flag holds", int'(rd_data), 128);
        reg_addr = 0;
        #1;
        check("R4 blank code", int'(rd_data), 255);

        // a read clears it
        step();
        reg_addr = 3; rd_stb = 1;
        step();
        rd_stb = 0;
        @(negedge clk);
        check("R7 cleared after read", int'(rd_data), 0);

        wait_pos(261, 255);
        step();
        @(negedge clk);
        check("R2 frame wrap", int'(line_out), 0);
        check("R9 one pulse with cmp 5", irq_cnt, 1);

        // disabled interrupt over a full frame
        write_reg(2, 0);
        irq_cnt = 0;
        wait_pos(3, 0);
        idle(10);
        wait_pos(0, 0);
        @(negedge clk);
        check("R9 no pulse with cmp 0", irq_cnt, 0);
        reg_addr = 0;
        #1;
        check("R3 line code", int'(rd_data), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule